// File: doc/BRIEF.md
# Three-Wire Synthesizer Programming Interface

This block is the configuration port of a frequency synthesizer. A host writes 20-bit words over three wires: a serial clock, a serial data line and a latch-enable line. The word enters a shift register most significant bit first. When latch enable rises, the two bits shifted in last are decoded, and the other 18 bits are copied into one of three latches. The first latch holds the feedback divider. The second holds the reference divider and three test bits. The third holds the standby level and the switch level. The latches drive the divider counters, the standby control and the open-drain switch directly.

The serial lines reach this block already synchronous to the system clock `clk`. The block finds their rising edges with one register stage per line. It also gates a raw lock indication from the phase detector. One test bit can force that indication low, and standby forces it high.

Top module: `synth_prog_port`

## Requirements
- R1: After reset, the feedback latch, the reference latch, `standby` and `sw_on` are 0, and `test_bits` is 3'b100 (lock detection enabled).
- R2: Each rising edge of `ser_clk` that is seen while `ser_le` is low shifts `ser_dat` into the shift register. A word is 20 bits and arrives MSB first: bits 19..2 are the payload (payload bit 17 is shifted first), bit 1 is the first control bit and bit 0 is the second control bit.
- R3: When the second control bit is 0, `fb_div` loads the 18 payload bits, whatever the first control bit is.
- R4: Control bits 1,1 select the reference latch. Payload bits 17..16 are ignored, bits 15..3 load `ref_div[12:0]`, and bits 2..0 load `test_bits[2:0]` (payload bit 2 is the lock-enable bit).
- R5: Control bits 0,1 select the control latch. Payload bit 17 loads `standby` and payload bit 16 loads `sw_on`. The remaining payload bits are ignored.
- R6: A latch is written only in the cycle in which a rising edge of `ser_le` is seen. Each word writes exactly one latch and leaves the other two unchanged.
- R7: While `ser_le` is high, `ser_clk` edges do not shift. This holds even when `ser_clk` rises in the same cycle that `ser_le` rises. A transfer does not clear the shift register, so a second pulse of `ser_le` loads the same word again.
- R8: When `standby` is 1, `lock_out` is 1. Otherwise `lock_out` equals `lock_in` while `test_bits[2]` is 1, and is 0 while `test_bits[2]` is 0.
- R9: All latched values are kept while `standby` is 1. `standby` changes only through a control-latch write.
- R10: `sw_on` is the open-drain enable. A value of 1 means the output transistor is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial shift clock, synchronous to clk |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Latch enable; the rising edge transfers the word |
| lock_in | input | 1 | Raw lock indication from the phase detector |
| fb_div | output | 18 | Feedback divider value |
| ref_div | output | 13 | Reference divider value |
| test_bits | output | 3 | Test bits; bit 2 enables lock detection |
| standby | output | 1 | Standby level |
| sw_on | output | 1 | Open-drain switch enable |
| lock_out | output | 1 | Gated lock indication |

## Verification
A serial clock edge and the transfer can fall in the same cycle. The bench provokes this by raising `ser_clk` and `ser_le` on the same drive edge, with a data bit chosen so that a shift would move the word to a different target latch. The result is judged twice. The latches must then hold the decode of the unshifted word. A second `ser_le` pulse with no clock in between must reload that same word, which shows the shift register neither moved nor cleared.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;

   typedef enum logic [1:0] {
      TGT_NONE = 2'd0,
      TGT_FB   = 2'd1,
      TGT_REF  = 2'd2,
      TGT_CTL  = 2'd3
   } tgt_e;

   // second control bit 0 -> feedback; 1,1 -> reference; 0,1 -> control
   function automatic tgt_e pick_target(input logic cb_first, input logic cb_second);
      if (!cb_second)    return TGT_FB;
      else if (cb_first) return TGT_REF;
      else               return TGT_CTL;
   endfunction

endpackage

// File: rtl/sp_shift.sv
module sp_shift #(
   parameter int FRAME_W = 20
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ser_clk,
   input  logic               ser_dat,
   input  logic               ser_le,
   output logic [FRAME_W-1:0] frame_o,
   output logic               xfer_o
);

   initial assert (FRAME_W >= 4) else $error("sp_shift: FRAME_W too small");

   logic               sclk_q;
   logic               le_q;
   logic [FRAME_W-1:0] sr_q;
   logic               sclk_rise;

   assign sclk_rise = ser_clk & ~sclk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q <= 1'b0;
         le_q   <= 1'b0;
         sr_q   <= '0;
      end else begin
         sclk_q <= ser_clk;
         le_q   <= ser_le;
         if (sclk_rise && !ser_le)
            sr_q <= {sr_q[FRAME_W-2:0], ser_dat};
      end
   end

   assign frame_o = sr_q;
   assign xfer_o  = ser_le & ~le_q;

   // R7: a high latch enable freezes the shift register
   assert_le_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ser_le |=> $stable(sr_q));

   // R2: a qualified serial edge puts the data bit at the LSB
   assert_shift_in_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_clk && !sclk_q && !ser_le) |=> (sr_q[0] == $past(ser_dat)));

endmodule

// File: rtl/sp_route.sv
module sp_route
   import synth_prog_pkg::*;
#(
   parameter int FRAME_W = 20,
   parameter int FB_W    = 18,
   parameter int REF_W   = 13,
   parameter int TEST_W  = 3,
   parameter int SKIP_W  = 2
) (
   input  logic               xfer,
   input  logic [FRAME_W-1:0] frame,
   output logic               fb_we,
   output logic               ref_we,
   output logic               ctl_we,
   output logic [FB_W-1:0]    fb_d,
   output logic [REF_W-1:0]   ref_d,
   output logic [TEST_W-1:0]  test_d,
   output logic               stby_d,
   output logic               sw_d
);

   localparam int PAY_W = FRAME_W - 2;

   initial assert (FB_W == PAY_W)
      else $error("sp_route: feedback field must fill the payload");
   initial assert (SKIP_W + REF_W + TEST_W == PAY_W)
      else $error("sp_route: reference layout must fill the payload");

   logic [PAY_W-1:0] payload;
   tgt_e             tgt;

   assign payload = frame[FRAME_W-1:2];

   always_comb begin
      tgt = TGT_NONE;
      if (xfer) tgt = pick_target(frame[1], frame[0]);
   end

   assign fb_we  = (tgt == TGT_FB);
   assign ref_we = (tgt == TGT_REF);
   assign ctl_we = (tgt == TGT_CTL);

   assign fb_d   = payload[FB_W-1:0];
   assign ref_d  = payload[TEST_W +: REF_W];
   assign test_d = payload[TEST_W-1:0];
   assign stby_d = payload[PAY_W-1];
   assign sw_d   = payload[PAY_W-2];

endmodule

// File: rtl/sp_regs.sv
module sp_regs #(
   parameter int                FB_W     = 18,
   parameter int                REF_W    = 13,
   parameter int                TEST_W   = 3,
   parameter logic [TEST_W-1:0] TEST_RST = 3'b100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fb_we,
   input  logic              ref_we,
   input  logic              ctl_we,
   input  logic [FB_W-1:0]   fb_d,
   input  logic [REF_W-1:0]  ref_d,
   input  logic [TEST_W-1:0] test_d,
   input  logic              stby_d,
   input  logic              sw_d,
   output logic [FB_W-1:0]   fb_q,
   output logic [REF_W-1:0]  ref_q,
   output logic [TEST_W-1:0] test_q,
   output logic              stby_q,
   output logic              sw_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fb_q   <= '0;
         ref_q  <= '0;
         stby_q <= 1'b0;
         sw_q   <= 1'b0;
      end else begin
         if (fb_we)  fb_q  <= fb_d;
         if (ref_we) ref_q <= ref_d;
         if (ctl_we) begin
            stby_q <= stby_d;
            sw_q   <= sw_d;
         end
      end
   end

   // each test bit carries its own reset value
   for (genvar i = 0; i < TEST_W; i++) begin : g_test
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      bit_q <= TEST_RST[i];
         else if (ref_we) bit_q <= test_d[i];
      end
      assign test_q[i] = bit_q;
   end

   // R6: at most one target latch per transfer
   assert_one_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({fb_we, ref_we, ctl_we}));

   // R6: feedback latch holds without its write
   assert_fb_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !fb_we |=> $stable(fb_q));

   // R9: standby set stays set until a control write
   assert_stby_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (stby_q && !ctl_we) |=> stby_q);

   // R9: standby clear stays clear until a control write
   assert_stby_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!stby_q && !ctl_we) |=> !stby_q);

   // R9: reference latch holds during standby unless written
   assert_ref_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (stby_q && !ref_we) |=> $stable(ref_q));

endmodule

// File: rtl/synth_prog_port.sv
module synth_prog_port #(
   parameter int FRAME_W = 20,
   parameter int FB_W    = 18,
   parameter int REF_W   = 13,
   parameter int TEST_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_clk,
   input  logic              ser_dat,
   input  logic              ser_le,
   input  logic              lock_in,
   output logic [FB_W-1:0]   fb_div,
   output logic [REF_W-1:0]  ref_div,
   output logic [TEST_W-1:0] test_bits,
   output logic              standby,
   output logic              sw_on,
   output logic              lock_out
);

   localparam int                SKIP_W   = FRAME_W - 2 - REF_W - TEST_W;
   localparam logic [TEST_W-1:0] TEST_RST = TEST_W'(1) << (TEST_W - 1);
   localparam int                LOCK_BIT = TEST_W - 1;

   logic [FRAME_W-1:0] frame;
   logic               xfer;
   logic               fb_we, ref_we, ctl_we;
   logic [FB_W-1:0]    fb_d;
   logic [REF_W-1:0]   ref_d;
   logic [TEST_W-1:0]  test_d;
   logic               stby_d, sw_d;

   sp_shift #(.FRAME_W(FRAME_W)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .ser_clk (ser_clk),
      .ser_dat (ser_dat),
      .ser_le  (ser_le),
      .frame_o (frame),
      .xfer_o  (xfer)
   );

   sp_route #(
      .FRAME_W (FRAME_W),
      .FB_W    (FB_W),
      .REF_W   (REF_W),
      .TEST_W  (TEST_W),
      .SKIP_W  (SKIP_W)
   ) u_route (
      .xfer   (xfer),
      .frame  (frame),
      .fb_we  (fb_we),
      .ref_we (ref_we),
      .ctl_we (ctl_we),
      .fb_d   (fb_d),
      .ref_d  (ref_d),
      .test_d (test_d),
      .stby_d (stby_d),
      .sw_d   (sw_d)
   );

   sp_regs #(
      .FB_W     (FB_W),
      .REF_W    (REF_W),
      .TEST_W   (TEST_W),
      .TEST_RST (TEST_RST)
   ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .fb_we  (fb_we),
      .ref_we (ref_we),
      .ctl_we (ctl_we),
      .fb_d   (fb_d),
      .ref_d  (ref_d),
      .test_d (test_d),
      .stby_d (stby_d),
      .sw_d   (sw_d),
      .fb_q   (fb_div),
      .ref_q  (ref_div),
      .test_q (test_bits),
      .stby_q (standby),
      .sw_q   (sw_on)
   );

   assign lock_out = standby | (lock_in & test_bits[LOCK_BIT]);

   // R8: a cleared lock-enable bit masks lock outside standby
   assert_lock_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!test_bits[LOCK_BIT] && !standby) |-> !lock_out);

   // R8: standby holds lock high
   assert_lock_stby_R8: assert property (@(posedge clk) disable iff (!rst_n)
      standby |-> lock_out);

endmodule

// File: tb/synth_prog_port_bench.sv
module synth_prog_port_bench;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ser_clk = 1'b0, ser_dat = 1'b0, ser_le = 1'b0, lock_in = 1'b0;
   logic [17:0] fb_div;
   logic [12:0] ref_div;
   logic [2:0]  test_bits;
   logic        standby, sw_on, lock_out;

   always #2 clk = ~clk;   // 250 MHz

   synth_prog_port u_synth_prog_port (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
      .ser_le(ser_le), .lock_in(lock_in), .fb_div(fb_div), .ref_div(ref_div),
      .test_bits(test_bits), .standby(standby), .sw_on(sw_on), .lock_out(lock_out)
   );

   int vectors = 0;
   int miscompares = 0;
   int cyc = 0;

   // bench model
   logic [19:0] m_sr = '0;
   logic [17:0] m_fb = '0;
   logic [12:0] m_ref = '0;
   logic [2:0]  m_test = 3'b100;
   logic        m_stby = 1'b0, m_sw = 1'b0;
   int          m_last = 0;   // 0 none, 1 fb, 2 ref, 3 ctl

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         miscompares++;
         $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 150000);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic send_bit(input logic b);
      @(negedge clk); ser_dat = b; ser_clk = 1'b0;
      @(negedge clk); ser_clk = 1'b1;
      m_sr = {m_sr[18:0], b};
   endtask

   task automatic model_xfer();
      logic [17:0] p;
      p = m_sr[19:2];
      if (!m_sr[0]) begin
         m_fb = p; m_last = 1;
      end else if (m_sr[1]) begin
         m_ref = p[15:3]; m_test = p[2:0]; m_last = 2;
      end else begin
         m_stby = p[17]; m_sw = p[16]; m_last = 3;
      end
   endtask

   task automatic pulse_le();
      @(negedge clk); ser_clk = 1'b0; ser_le = 1'b1;
      model_xfer();
      @(negedge clk); ser_le = 1'b0;
      @(negedge clk);
   endtask

   task automatic check_all();
      chk(m_last == 1 ? "R2/R3 fb_div" : "R6 fb_div", 32'(fb_div), 32'(m_fb));
      chk(m_last == 2 ? "R4 ref_div" : "R6 ref_div", 32'(ref_div), 32'(m_ref));
      chk(m_last == 2 ? "R4 test_bits" : "R6 test_bits", 32'(test_bits), 32'(m_test));
      chk(m_last == 3 ? "R5 standby" : "R6 standby", 32'(standby), 32'(m_stby));
      chk(m_last == 3 ? "R10 sw_on" : "R6 sw_on", 32'(sw_on), 32'(m_sw));
      for (int l = 0; l < 2; l++) begin
         lock_in = l[0];
         #0.5;
         chk("R8 lock_out", 32'(lock_out), 32'(m_stby | (lock_in & m_test[2])));
      end
   endtask

   task automatic write_word(input logic [17:0] p, input logic cb1, input logic cb0);
      logic [19:0] w;
      w = {p, cb1, cb0};
      for (int i = 19; i >= 0; i--) send_bit(w[i]);
      pulse_le();
      check_all();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 fb_div", 32'(fb_div), 0);
      chk("R1 ref_div", 32'(ref_div), 0);
      chk("R1 test_bits", 32'(test_bits), 32'h4);
      chk("R1 standby", 32'(standby), 0);
      chk("R1 sw_on", 32'(sw_on), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check_all();

      // walking ones and zeros over every target
      for (int cb = 0; cb < 4; cb++) begin
         for (int k = 0; k < 18; k++) begin
            write_word(18'(1) << k, cb[1], cb[0]);
            write_word(~(18'(1) << k), cb[1], cb[0]);
         end
      end
      // arithmetic sweep
      for (int k = 0; k < 24; k++) begin
         write_word(18'((k * 7919 + 4032) % 262144), k[1], k[0]);
      end

      // R9: standby on, other writes kept, standby persists
      write_word(18'h20000, 1'b0, 1'b1);
      chk("R9 standby set", 32'(standby), 1);
      write_word(18'd10000, 1'b1, 1'b0);
      chk("R9 fb in standby", 32'(fb_div), 32'd10000);
      chk("R9 standby kept", 32'(standby), 1);
      write_word(18'h0ABCD, 1'b1, 1'b1);
      chk("R9 standby kept ref", 32'(standby), 1);
      write_word(18'h10000, 1'b0, 1'b1);
      chk("R9 standby cleared", 32'(standby), 0);
      chk("R10 sw_on set", 32'(sw_on), 1);

      // R7: serial edge and latch enable in the same cycle
      write_word(18'd4032, 1'b1, 1'b0);          // register ends ...,1,0
      @(negedge clk); ser_dat = 1'b1; ser_clk = 1'b1; ser_le = 1'b1;
      model_xfer();                              // no shift: reloads feedback word
      @(negedge clk); ser_le = 1'b0; ser_clk = 1'b0;
      @(negedge clk);
      check_all();
      chk("R7 no shift on le", 32'(m_last), 1);
      write_word(18'h3FFFF, 1'b0, 1'b1);         // change control latch
      write_word(18'd5000, 1'b0, 1'b0);
      pulse_le();                                // re-pulse: same word again
      check_all();
      chk("R7 reload fb", 32'(fb_div), 32'd5000);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule